// File: doc/BRIEF.md
# Glitch-Free Segment-Mapped Switching Clock Selector

This block produces the switching clock for a segmented switched-capacitor output stage. A quantizer reports how many switch segments are enabled (a level from 0 to 8), and the block turns that level into one of four fixed switching frequencies. Each frequency is a power-of-two division of one fast reference clock, and all four are taken from one shared free-running counter. The block drives the chosen clock to the downstream non-overlap generator. It also reports a 2-bit code that tells which frequency is in use.

Naively multiplexing divided clocks can stretch a phase when the selection moves. For example, going from a 2-cycle phase to a 1-cycle phase can leave one 3-cycle phase. This block avoids that. A new frequency is taken up only on a counter value where both the old clock and the new clock have a rising edge. Because of this, every phase is exactly a half-period of either the old clock or the new clock. At level 0 the clock finishes its current high phase and then stays low. When the level leaves 0, the clock restarts on an aligned rising edge.

Top module: `fsel_clock_selector`

## Requirements
- R1: While reset is asserted, sw_clk is 0 and freq_code is 0.
- R2: Levels 1 and 2 select freq_code 0 (reference divided by 64). Levels 3 and 4 select code 1 (divide by 8). Levels 5 and 6 select code 2 (divide by 4). Levels 7 and 8 select code 3 (divide by 2).
- R3: In steady operation, sw_clk is high for exactly half of the selected divide ratio in reference cycles, and low for the same number of cycles.
- R4: An internal counter is 0 at reset and advances by one on every reference edge. sw_clk rises only on an edge k (counted from reset release) where k is a multiple of the divide ratio shown on freq_code.
- R5: When the frequency changes, every low phase lasts the half-period of either the old frequency or the new one. No phase is ever longer than the half-period of the slower frequency.
- R6: freq_code changes only on the edge where sw_clk rises into the new frequency. The change happens within 64 reference edges of the level change.
- R7: Level 0 lets the current high phase complete. After that, sw_clk is held low and freq_code keeps its last value.
- R8: When the level leaves 0, sw_clk first rises on an edge aligned to the new divide ratio. That first high phase has its full length.
- R9: Levels 9 to 15 are treated as level 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock that all frequencies are divided from |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_level | input | 4 | Number of enabled switch segments (0 means off) |
| sw_clk | output | 1 | Selected switching clock, registered |
| freq_code | output | 2 | Code of the frequency in use (0 is slowest, 3 is fastest) |

## Verification
sw_clk comes from a register loaded with the counter's next value. A rising edge therefore appears right after the reference edge whose count is a multiple of the ratio. freq_code is updated on that same edge. All outputs are sampled at the falling reference edge, and the bench keeps its own count of edges since reset release. A level change must be visible on freq_code within 64 edges, and the bench allows exactly that window. A monitor measures the length of every high and low phase and compares it with the half-periods of the codes in effect around that phase. The alignment check uses the bench's own edge count.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int unsigned CODE_W = 2;

    typedef logic [CODE_W-1:0] fcode_t;

    typedef struct packed {
        logic   run;
        fcode_t sel;
        logic   out;
    } sw_state_t;

endpackage

// File: rtl/fsel_level_map.sv
module fsel_level_map
    import fsel_pkg::*;
#(
    parameter int unsigned LEVEL_W   = 4,
    parameter int unsigned MAX_LEVEL = 8
) (
    input  logic [LEVEL_W-1:0] level_i,
    output logic               on_o,
    output fcode_t             code_o
);

    localparam int unsigned NUM_FREQ     = 2 ** CODE_W;
    localparam int unsigned LVL_PER_CODE = MAX_LEVEL / NUM_FREQ;

    logic [LEVEL_W-1:0] lvl_clamped;

    always_comb begin
        lvl_clamped = (int'(level_i) > int'(MAX_LEVEL)) ? LEVEL_W'(MAX_LEVEL) : level_i;
        on_o        = (lvl_clamped != '0);
        code_o      = '0;
        if (on_o) begin
            code_o = CODE_W'((int'(lvl_clamped) - 1) / int'(LVL_PER_CODE));
        end
    end

endmodule

// File: rtl/fsel_phase_ctr.sv
module fsel_phase_ctr #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_n_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_q_o = cnt_q;
    assign cnt_n_o = cnt_d;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/fsel_clk_switch.sv
module fsel_clk_switch
    import fsel_pkg::*;
#(
    parameter int unsigned CNT_W                   = 6,
    parameter int          DIV_BIT [2 ** CODE_W]   = '{5, 2, 1, 0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_on_i,
    input  fcode_t           req_code_i,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [CNT_W-1:0] cnt_n_i,
    output logic             sw_clk_o,
    output fcode_t           code_o
);

    localparam int unsigned NUM_FREQ = 2 ** CODE_W;
    localparam int unsigned IDX_W    = (CNT_W > 1) ? $clog2(CNT_W) : 1;

    typedef logic [IDX_W-1:0] idx_t;

    function automatic idx_t div_of(fcode_t c);
        idx_t r = '0;
        for (int i = 0; i < NUM_FREQ; i++) begin
            if (c == CODE_W'(i)) r = IDX_W'(DIV_BIT[i]);
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] low_mask(idx_t b);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < CNT_W; i++) begin
            m[i] = (i <= int'(b));
        end
        return m;
    endfunction

    sw_state_t st_d, st_q;
    idx_t      b_cur, b_req, b_big;
    logic      req_aligned, both_aligned;

    always_comb begin
        st_d         = st_q;
        b_cur        = div_of(st_q.sel);
        b_req        = div_of(req_code_i);
        b_big        = (b_req > b_cur) ? b_req : b_cur;
        req_aligned  = ((cnt_n_i & low_mask(b_req)) == '0);
        both_aligned = ((cnt_n_i & low_mask(b_big)) == '0);

        if (!st_q.run) begin
            st_d.out = 1'b0;
            if (req_on_i && req_aligned) begin
                st_d.run = 1'b1;
                st_d.sel = req_code_i;
                st_d.out = 1'b1;
            end
        end else if (!req_on_i) begin
            if (!st_q.out) begin
                st_d.run = 1'b0;
                st_d.out = 1'b0;
            end else begin
                st_d.out = ~cnt_n_i[b_cur];
                st_d.run = st_d.out;
            end
        end else begin
            if ((req_code_i != st_q.sel) && both_aligned) begin
                st_d.sel = req_code_i;
            end
            st_d.out = ~cnt_n_i[div_of(st_d.sel)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_clk_o = st_q.out;
    assign code_o   = st_q.sel;

    AST_SEL_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel != $past(st_q.sel)) |-> (st_q.out && !$past(st_q.out))); // R6

    AST_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.out) |-> ((cnt_q_i & low_mask(div_of(st_q.sel))) == '0)); // R4

    AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!req_on_i) && !$past(st_q.out)) |-> !st_q.out); // R7

endmodule

// File: rtl/fsel_clock_selector.sv
module fsel_clock_selector
    import fsel_pkg::*;
#(
    parameter int unsigned LEVEL_W                = 4,
    parameter int unsigned MAX_LEVEL              = 8,
    parameter int unsigned CNT_W                  = 6,
    parameter int          DIV_BIT [2 ** CODE_W]  = '{5, 2, 1, 0}
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] seg_level,
    output logic               sw_clk,
    output logic [CODE_W-1:0]  freq_code
);

    logic             req_on;
    fcode_t           req_code;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    fcode_t           code;

    fsel_level_map #(
        .LEVEL_W   (LEVEL_W),
        .MAX_LEVEL (MAX_LEVEL)
    ) u_map (
        .level_i (seg_level),
        .on_o    (req_on),
        .code_o  (req_code)
    );

    fsel_phase_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .cnt_q_o (cnt_q),
        .cnt_n_o (cnt_n)
    );

    fsel_clk_switch #(
        .CNT_W   (CNT_W),
        .DIV_BIT (DIV_BIT)
    ) u_sw (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .req_on_i   (req_on),
        .req_code_i (req_code),
        .cnt_q_i    (cnt_q),
        .cnt_n_i    (cnt_n),
        .sw_clk_o   (sw_clk),
        .code_o     (code)
    );

    assign freq_code = code;

    AST_CODE_HELD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$rose(sw_clk) |-> $stable(freq_code)); // R6

endmodule

// File: tb/fsel_clock_selector_test.sv
`timescale 1ns/1ps
module fsel_clock_selector_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] level = 4'd0;
    logic       sw_clk;
    logic [1:0] freq_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int k = 0;
    bit mon_en = 0;
    bit off_seen = 1;
    int run_len = 0;
    logic prev_sw = 1'b0;
    logic [1:0] prev_code = 2'd0;
    logic [1:0] last_fall_code = 2'd0;

    fsel_clock_selector uut (
        .ref_clk   (clk),
        .rst_n     (rst_n),
        .seg_level (level),
        .sw_clk    (sw_clk),
        .freq_code (freq_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    function automatic int half_of(logic [1:0] c);
        case (c)
            2'd0:    return 32;
            2'd1:    return 4;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [1:0] code_of(int lvl);
        int l = (lvl > 8) ? 8 : lvl;
        if (l <= 2) return 2'd0;
        if (l <= 4) return 2'd1;
        if (l <= 6) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // phase monitor: R3 high phases, R4 alignment, R5 low phases, R6 code timing
    always @(negedge clk) begin
        if (mon_en && !done) begin
            if (sw_clk != prev_sw) begin
                if (sw_clk) begin
                    check((k % (2 * half_of(freq_code))) == 0, "R4", "rise edge index mod ratio",
                          k % (2 * half_of(freq_code)), 0);
                    if (!off_seen) begin
                        check(run_len == half_of(freq_code) || run_len == half_of(last_fall_code),
                              "R5", "low phase length", run_len, half_of(freq_code));
                    end
                    off_seen = 0;
                end else begin
                    check(run_len == half_of(freq_code), "R3", "high phase length",
                          run_len, half_of(freq_code));
                    last_fall_code = freq_code;
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            if (freq_code != prev_code) begin
                check(sw_clk && !prev_sw, "R6", "code change on rising edge", int'(sw_clk), 1);
            end
            prev_sw   = sw_clk;
            prev_code = freq_code;
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise(int max_n, output int n, output bit found);
        logic p = sw_clk;
        found = 0;
        n = 0;
        for (int i = 1; i <= max_n; i++) begin
            @(negedge clk);
            if (sw_clk && !p) begin
                n = i;
                found = 1;
                break;
            end
            p = sw_clk;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        level = 4'd8;
        wait_cycles(5);
        check(sw_clk == 1'b0, "R1", "sw_clk in reset", int'(sw_clk), 0);
        check(freq_code == 2'd0, "R1", "freq_code in reset", int'(freq_code), 0);
        level = 4'd0;
        rst_n = 1'b1;
        mon_en = 1;
        wait_cycles(3);
    endtask

    task automatic t_steady(int lvl);
        int n1, n2;
        bit f1, f2;
        logic [1:0] exp = code_of(lvl);
        level = 4'(lvl);
        wait_cycles(150);
        if (lvl > 8) check(freq_code == exp, "R9", "clamped level code", int'(freq_code), int'(exp));
        else         check(freq_code == exp, "R2", "level to code", int'(freq_code), int'(exp));
        wait_rise(140, n1, f1);
        wait_rise(140, n2, f2);
        check(f1 && f2 && n2 == 2 * half_of(exp), "R3", "steady period", n2, 2 * half_of(exp));
    endtask

    task automatic t_switch(int a, int b);
        int n = 0;
        bit hit = 0;
        logic [1:0] ea = code_of(a);
        logic [1:0] eb = code_of(b);
        level = 4'(a);
        wait_cycles(150);
        check(freq_code == ea, "R2", "code before switch", int'(freq_code), int'(ea));
        level = 4'(b);
        for (int i = 1; i <= 80; i++) begin
            @(negedge clk);
            if (!hit && freq_code == eb) begin
                hit = 1;
                n = i;
            end
            if (ea == eb && freq_code != ea) hit = 0;
        end
        if (ea == eb) begin
            check(hit && freq_code == ea, "R6", "same code level move keeps code",
                  int'(freq_code), int'(ea));
        end else begin
            check(hit && n <= 64, "R6", "switch latency", n, 64);
        end
        wait_cycles(150);
    endtask

    task automatic t_off_and_restart();
        int n, highs;
        bit f;
        level = 4'd2;
        wait_cycles(150);
        wait_rise(140, n, f);
        wait_cycles(5);
        off_seen = 1;
        level = 4'd0;
        wait_cycles(40);
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sw_clk) highs++;
        end
        check(highs == 0, "R7", "high samples while off", highs, 0);
        check(freq_code == 2'd0, "R7", "code kept while off", int'(freq_code), 0);
        level = 4'd5;
        wait_rise(8, n, f);
        check(f && n <= 4, "R8", "restart rise latency", n, 4);
        @(negedge clk);
        check(sw_clk == 1'b1, "R8", "restart high phase second cycle", int'(sw_clk), 1);
        @(negedge clk);
        check(sw_clk == 1'b0, "R8", "restart high phase ends", int'(sw_clk), 0);
        check(freq_code == 2'd2, "R8", "restart code", int'(freq_code), 2);
        wait_cycles(100);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        for (int l = 1; l <= 8; l++) t_steady(l);
        t_steady(12);
        t_steady(15);
        t_switch(4, 6);
        t_switch(6, 4);
        t_switch(8, 2);
        t_switch(2, 8);
        t_switch(3, 7);
        t_switch(1, 5);
        t_switch(3, 4);
        t_off_and_restart();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule